// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor from normal execution into an exception handler. On a strobe it takes a set of pending cause flags, picks the most urgent one, and looks up the handler mode and the vector offset for that cause. It moves the vector to the top of the address space when the high-vector control bit is set. It then runs a fixed three-step entry. First it asks the register-bank switcher to swap banks. Next it writes the full captured status word into the saved-status register. Last it writes the new status word (new mode, interrupts masked), the link register, the program counter and a one-cycle pipeline flush.

The values captured on the strobe drive every step. An entry takes three cycles. While an entry is in progress, `busy` is high and any new strobe is dropped. A strobe with no recognised cause flag performs no entry. It raises `cause_err` for one cycle instead. All pins are plain control or status pins. The strobe carries no handshake: the surrounding core must present it only while `busy` is low.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, `busy`, `bank_req`, `ssr_we`, `sr_we`, `lr_we`, `pc_we`, `flush` and `cause_err` are all low.
- R2: Cause flag bits are [0] privilege, [1] instruction abort, [2] data abort and [3] interrupt; bits [7:4] are reserved. The mode field codes are 0x13 (privileged), 0x17 (trap) and 0x12 (interrupt). Each cause maps to a mode and a vector offset: privilege to mode 0x13 at offset 0x08, instruction abort to mode 0x17 at 0x0C, data abort to mode 0x17 at 0x10, interrupt to mode 0x12 at 0x18.
- R3: When several defined flags are set together, the winner is chosen in this order: data abort, then instruction abort, then interrupt, then privilege. Reserved bits are ignored.
- R4: When `hivec_en` is high at the strobe, the vector is the offset plus 0xFFFF0000. Otherwise the vector is the offset alone.
- R5: In the first cycle after an accepted strobe, `bank_req` is high with `bank_from_mode` equal to status bits [4:0] and `bank_to_mode` equal to the new mode. If the two modes are equal, `bank_req` stays low.
- R6: In the second cycle, `ssr_we` is high and `ssr_wdata` equals the complete status word captured at the strobe.
- R7: In the third cycle, `sr_we`, `lr_we`, `pc_we` and `flush` are high together. `sr_wdata` is the captured status with bits [4:0] replaced by the new mode and bit 7 set. `lr_wdata` is the captured program counter. `pc_wdata` is the vector. `flush` lasts exactly one cycle.
- R8: A strobe with none of bits [3:0] set raises `cause_err` for one cycle after the strobe. It starts no entry and causes no write.
- R9: A strobe that arrives while `busy` is high is ignored. Changes on the data inputs during an entry do not affect its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception strobe |
| exc_cause | input | 8 | Pending cause flags |
| cur_status | input | 32 | Current status word |
| cur_pc | input | 32 | Current program counter |
| hivec_en | input | 1 | High-vector relocation control |
| busy | output | 1 | Entry in progress |
| bank_req | output | 1 | Bank switch request |
| bank_from_mode | output | 5 | Mode being left |
| bank_to_mode | output | 5 | Mode being entered |
| ssr_we | output | 1 | Saved-status write enable |
| ssr_wdata | output | 32 | Saved-status write value |
| sr_we | output | 1 | Status write enable |
| sr_wdata | output | 32 | New status word |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | 32 | Link register value |
| pc_we | output | 1 | Program counter write enable |
| pc_wdata | output | 32 | Vector address |
| flush | output | 1 | Pipeline flush pulse |
| cause_err | output | 1 | Unknown cause indication |

## Verification
The assertions assume three things about the inputs: reset is applied before the first strobe, the strobe is a clean level sampled at the clock edge, and every offset in the cause table is word aligned. The ordering checks also depend on the strobe being acted on only while the block is idle. The stimulus changes inputs only on falling edges. It sends a new strobe only once `busy` is low, except in the one directed case that tests a strobe during an entry.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN      = 32;
  localparam int MODE_W    = 5;
  localparam int CAUSE_W   = 8;
  localparam int OFS_W     = 8;
  localparam int IMASK_BIT = 7;
  localparam logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000;

  localparam logic [MODE_W-1:0] MODE_PRIV = 5'h13;
  localparam logic [MODE_W-1:0] MODE_TRAP = 5'h17;
  localparam logic [MODE_W-1:0] MODE_INTR = 5'h12;

  localparam int C_PRIV  = 0;
  localparam int C_IABT  = 1;
  localparam int C_DABT  = 2;
  localparam int C_IRQ   = 3;
  localparam int NCAUSE  = 4;

  typedef enum logic [1:0] {S_IDLE, S_BANK, S_SAVE, S_COMMIT} seq_state_t;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [OFS_W-1:0]  offset;
  } vec_entry_t;
endpackage

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
  import exc_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause,
  output logic               known,
  output vec_entry_t         sel
);
  localparam vec_entry_t ENT_PRIV = '{mode: MODE_PRIV, offset: 8'h08};
  localparam vec_entry_t ENT_IABT = '{mode: MODE_TRAP, offset: 8'h0C};
  localparam vec_entry_t ENT_DABT = '{mode: MODE_TRAP, offset: 8'h10};
  localparam vec_entry_t ENT_IRQ  = '{mode: MODE_INTR, offset: 8'h18};

  logic [NCAUSE-1:0] defined;
  assign defined = cause[NCAUSE-1:0];
  assign known   = |defined;

  // fixed priority: data abort > instruction abort > interrupt > privilege
  always_comb begin
    sel = ENT_PRIV;
    if (defined[C_DABT])      sel = ENT_DABT;
    else if (defined[C_IABT]) sel = ENT_IABT;
    else if (defined[C_IRQ])  sel = ENT_IRQ;
    else                      sel = ENT_PRIV;
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
(
  input  logic [OFS_W-1:0] offset,
  input  logic             hivec,
  output logic [XLEN-1:0]  vector
);
  logic [XLEN-1:0] base;
  assign base   = hivec ? HIVEC_BASE : '0;
  assign vector = base + {{(XLEN-OFS_W){1'b0}}, offset};
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              known,
  input  logic [MODE_W-1:0] tgt_mode,
  input  logic [XLEN-1:0]   vector,
  input  logic              hivec,
  input  logic [XLEN-1:0]   status,
  input  logic [XLEN-1:0]   pc,
  output logic              busy,
  output logic              bank_req,
  output logic [MODE_W-1:0] bank_from_mode,
  output logic [MODE_W-1:0] bank_to_mode,
  output logic              ssr_we,
  output logic [XLEN-1:0]   ssr_wdata,
  output logic              sr_we,
  output logic [XLEN-1:0]   sr_wdata,
  output logic              lr_we,
  output logic [XLEN-1:0]   lr_wdata,
  output logic              pc_we,
  output logic [XLEN-1:0]   pc_wdata,
  output logic              flush,
  output logic              cause_err
);
  localparam logic [XLEN-1:0] MODE_MASK  = XLEN'((64'd1 << MODE_W) - 64'd1);
  localparam logic [XLEN-1:0] IMASK_FLAG = XLEN'(64'd1 << IMASK_BIT);

  seq_state_t        state_q;
  logic [MODE_W-1:0] mode_q;
  logic [XLEN-1:0]   vec_q, st_q, pc_q;
  logic              hv_q, err_q;
  logic              accept;

  assign accept = (state_q == S_IDLE) && strobe && known;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= '0;
      vec_q   <= '0;
      st_q    <= '0;
      pc_q    <= '0;
      hv_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (state_q == S_IDLE) && strobe && !known;
      unique case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_BANK;
          mode_q  <= tgt_mode;
          vec_q   <= vector;
          st_q    <= status;
          pc_q    <= pc;
          hv_q    <= hivec;
        end
        S_BANK:   state_q <= S_SAVE;
        S_SAVE:   state_q <= S_COMMIT;
        S_COMMIT: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign busy           = (state_q != S_IDLE);
  assign bank_from_mode = st_q[MODE_W-1:0];
  assign bank_to_mode   = mode_q;
  assign bank_req       = (state_q == S_BANK) && (bank_from_mode != mode_q);
  assign ssr_we         = (state_q == S_SAVE);
  assign ssr_wdata      = st_q;
  assign sr_we          = (state_q == S_COMMIT);
  assign sr_wdata       = (st_q & ~MODE_MASK) | {{(XLEN-MODE_W){1'b0}}, mode_q} | IMASK_FLAG;
  assign lr_we          = sr_we;
  assign lr_wdata       = pc_q;
  assign pc_we          = sr_we;
  assign pc_wdata       = vec_q;
  assign flush          = sr_we;
  assign cause_err      = err_q;

  // R6: the saved-status write follows the bank step
  a_r6_save_after_bank: assert property (@(posedge clk) disable iff (!rst_n)
    ssr_we |-> $past(state_q) == S_BANK);
  // R7: the commit follows the saved-status write
  a_r7_commit_after_save: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |-> $past(ssr_we));
  a_r7_imask_set: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |-> sr_wdata[IMASK_BIT]);
  a_r7_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  // R4: relocation follows the captured control bit
  a_r4_high_reloc: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (hv_q == (pc_wdata >= HIVEC_BASE)));
  a_r2_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (pc_wdata[1:0] == 2'b00));
  // R8: an unknown cause never starts an entry
  a_r8_err_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    cause_err |-> (!busy && !ssr_we && !sr_we));
  // R9: captured values hold for the whole entry
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(vec_q) && $stable(st_q) && $stable(pc_q)));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic [XLEN-1:0]   cur_status,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              hivec_en,
  output logic              busy,
  output logic              bank_req,
  output logic [MODE_W-1:0] bank_from_mode,
  output logic [MODE_W-1:0] bank_to_mode,
  output logic              ssr_we,
  output logic [XLEN-1:0]   ssr_wdata,
  output logic              sr_we,
  output logic [XLEN-1:0]   sr_wdata,
  output logic              lr_we,
  output logic [XLEN-1:0]   lr_wdata,
  output logic              pc_we,
  output logic [XLEN-1:0]   pc_wdata,
  output logic              flush,
  output logic              cause_err
);
  logic            known;
  vec_entry_t      sel;
  logic [XLEN-1:0] vector;

  exc_cause_sel u_sel (.cause(exc_cause), .known(known), .sel(sel));

  exc_vector_gen u_vec (.offset(sel.offset), .hivec(hivec_en), .vector(vector));

  exc_entry_seq u_seq (
    .clk(clk), .rst_n(rst_n), .strobe(exc_valid), .known(known),
    .tgt_mode(sel.mode), .vector(vector), .hivec(hivec_en),
    .status(cur_status), .pc(cur_pc),
    .busy(busy), .bank_req(bank_req), .bank_from_mode(bank_from_mode),
    .bank_to_mode(bank_to_mode), .ssr_we(ssr_we), .ssr_wdata(ssr_wdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .lr_we(lr_we), .lr_wdata(lr_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .flush(flush), .cause_err(cause_err)
  );

  // R1: nothing is written while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bank_req && !ssr_we && !sr_we && !flush));
  // R5: bank request only for a real mode change
  a_r5_bank_diff: assert property (@(posedge clk) disable iff (!rst_n)
    bank_req |-> (bank_from_mode != bank_to_mode));
endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_valid;
  logic [7:0]  exc_cause;
  logic [31:0] cur_status, cur_pc;
  logic        hivec_en;
  logic        busy, bank_req, ssr_we, sr_we, lr_we, pc_we, flush, cause_err;
  logic [4:0]  bank_from_mode, bank_to_mode;
  logic [31:0] ssr_wdata, sr_wdata, lr_wdata, pc_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_entry_unit u_exc_entry_unit (.*);

  localparam int N = 8;
  localparam logic [7:0]  T_CAUSE [N] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h0F, 8'h0B, 8'h09, 8'h31};
  localparam logic [31:0] T_ST    [N] = '{32'h0000_0010, 32'h6000_0010, 32'h0000_0010, 32'hF000_0053,
                                          32'h1234_5610, 32'h0000_0012, 32'h8000_0113, 32'h0000_0097};
  localparam logic [31:0] T_PC    [N] = '{32'h0000_1000, 32'h0000_2004, 32'h0000_3008, 32'h0000_400C,
                                          32'hABCD_0000, 32'h0000_5550, 32'h7FFF_FFFC, 32'h0000_0040};
  localparam logic        T_HV    [N] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [4:0]  T_MODE  [N] = '{5'h13, 5'h17, 5'h17, 5'h12, 5'h17, 5'h17, 5'h12, 5'h13};
  localparam logic [31:0] T_VEC   [N] = '{32'h08, 32'h0C, 32'hFFFF_0010, 32'hFFFF_0018,
                                          32'h10, 32'hFFFF_000C, 32'h18, 32'hFFFF_0008};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_entry(input logic [7:0] c, input logic [31:0] st, input logic [31:0] pc,
                           input logic hv, input logic [4:0] m, input logic [31:0] v, input string tag);
    logic [31:0] exp_sr;
    exp_sr = (st & ~32'h1F) | {27'd0, m} | 32'h80;
    exc_valid = 1'b1; exc_cause = c; cur_status = st; cur_pc = pc; hivec_en = hv;
    @(negedge clk);
    exc_valid = 1'b0;
    // R5: bank step
    check(bank_req == (st[4:0] != m), {tag, " R5 bank_req"}, {31'd0, bank_req}, {31'd0, st[4:0] != m});
    check(bank_to_mode == m, {tag, " R2 mode"}, {27'd0, bank_to_mode}, {27'd0, m});
    check(bank_from_mode == st[4:0], {tag, " R5 from"}, {27'd0, bank_from_mode}, {27'd0, st[4:0]});
    // R9: disturb inputs during entry
    cur_status = 32'hDEAD_BEEF; cur_pc = 32'h1111_1111; hivec_en = ~hv;
    @(negedge clk);
    check(ssr_we && !sr_we, {tag, " R6 save step"}, {30'd0, ssr_we, sr_we}, 32'h2);
    check(ssr_wdata == st, {tag, " R6 ssr"}, ssr_wdata, st);
    @(negedge clk);
    check(sr_we && lr_we && pc_we && flush, {tag, " R7 commit"}, {28'd0, sr_we, lr_we, pc_we, flush}, 32'hF);
    check(sr_wdata == exp_sr, {tag, " R7 sr"}, sr_wdata, exp_sr);
    check(lr_wdata == pc, {tag, " R7 lr"}, lr_wdata, pc);
    check(pc_wdata == v, {tag, " R4 vector"}, pc_wdata, v);
    @(negedge clk);
    check(!flush && !busy && !sr_we, {tag, " R7 flush single"}, {30'd0, flush, busy}, 32'h0);
  endtask

  initial begin
    exc_valid = 1'b0; exc_cause = '0; cur_status = '0; cur_pc = '0; hivec_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !bank_req && !ssr_we && !sr_we && !lr_we && !pc_we && !flush && !cause_err,
          "R1 reset", {24'd0, busy, bank_req, ssr_we, sr_we, lr_we, pc_we, flush, cause_err}, 32'h0);

    // R2 R3 R4 table
    for (int i = 0; i < N; i++)
      run_entry(T_CAUSE[i], T_ST[i], T_PC[i], T_HV[i], T_MODE[i], T_VEC[i], $sformatf("vec%0d R3", i));

    // R5: same mode, no bank request
    run_entry(8'h02, 32'h0000_0017, 32'h0000_0100, 1'b0, 5'h17, 32'h0C, "same-mode R5");

    // R8: unknown causes
    exc_valid = 1'b1; exc_cause = 8'h00;
    @(negedge clk);
    exc_valid = 1'b0;
    check(cause_err && !busy, "R8 err zero cause", {30'd0, cause_err, busy}, 32'h2);
    @(negedge clk);
    check(!cause_err && !busy && !ssr_we && !sr_we, "R8 err single", {30'd0, cause_err, busy}, 32'h0);
    exc_valid = 1'b1; exc_cause = 8'hF0;
    @(negedge clk);
    exc_valid = 1'b0;
    check(cause_err && !busy, "R8 err reserved only", {30'd0, cause_err, busy}, 32'h2);
    repeat (3) begin
      @(negedge clk);
      check(!ssr_we && !sr_we && !pc_we, "R8 no write", {29'd0, ssr_we, sr_we, pc_we}, 32'h0);
    end

    // R9: strobe held during an entry is ignored
    exc_valid = 1'b1; exc_cause = 8'h01; cur_status = 32'h10; cur_pc = 32'h900; hivec_en = 1'b0;
    @(negedge clk);
    exc_cause = 8'h04; hivec_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    exc_valid = 1'b0;
    check(pc_wdata == 32'h08 && pc_we, "R9 busy strobe ignored", pc_wdata, 32'h08);
    @(negedge clk);
    check(!busy, "R9 no second entry", {31'd0, busy}, 32'h0);
    @(negedge clk);
    check(!bank_req && !busy, "R9 idle", {30'd0, bank_req, busy}, 32'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule